// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits between a UART receiver, a UART transmitter and a receive FIFO. It watches the stream of received bytes for configured flow-control characters. A matched stop character pauses the local transmitter and a matched resume character lets it run again. It also watches the receive FIFO fill level. When the level reaches the upper mark, it asks the transmitter to insert a stop character, or a pair of them. When the level later falls to the lower mark, it asks for a resume character, or a pair.

A 4-bit mode field sets the two directions separately. Bits [3:2] choose which characters the receiver matches. Bits [1:0] choose which characters the transmitter inserts. There are two character sets, a first set (XON1/XOFF1) and a second set (XON2/XOFF2). A direction can use either set alone, or both sets as a two-character sequence. An option replaces the low nibble of the second stop character, for matching only, with the levels on four address pins. This lets a board strap a node address, for example on an RS-485 bus.

The receive path is a three-state machine:
- RX_IDLE moves to RX_HAVE_ON on an XON1 byte, or to RX_HAVE_OFF on an XOFF1 byte, in pair mode only.
- RX_HAVE_ON moves back to RX_IDLE when XON2 completes the pair.
- RX_HAVE_OFF moves back to RX_IDLE when XOFF2 completes the pair.
- In both waiting states, a first-set character restarts the sequence and any other byte returns to RX_IDLE.

The insertion path is a six-state machine:
- TQ_ON_WAIT moves to TQ_OFF_A when the level is at or above the upper mark.
- TQ_OFF_A moves to TQ_OFF_B in pair mode, or to TQ_OFF_WAIT otherwise, on acceptance.
- TQ_OFF_B moves to TQ_OFF_WAIT on acceptance.
- TQ_OFF_WAIT moves to TQ_ON_A when the level is at or below the lower mark.
- TQ_ON_A moves to TQ_ON_B in pair mode, or to TQ_ON_WAIT otherwise, on acceptance.
- TQ_ON_B moves to TQ_ON_WAIT on acceptance.
- Any state moves to TQ_ON_WAIT when insertion is disabled.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset, `tx_paused` is 0, `spec_det` is 0 and `tx_ins_valid` is 0.
- R2: The two mode halves act independently. With mode bits [3:2] = 00, no received byte changes `tx_paused` or raises `spec_det`. With mode bits [1:0] = 00, no character is ever inserted.
- R3: With mode bits [3:2] = 10, a received XOFF1 byte sets `tx_paused` and a received XON1 byte clears it. Either match pulses `spec_det` for one cycle, on the edge after the byte's cycle. `spec_code` reports the match: 0 = XON1, 1 = XON2, 2 = XOFF1, 3 = XOFF2.
- R4: With mode bits [3:2] = 01, a received XOFF2 byte pauses the transmitter with code 3, and a received XON2 byte resumes it with code 1. First-set bytes have no effect.
- R5: With mode bits [3:2] = 11, only the pair XON1 then XON2 resumes, with code 1, and only the pair XOFF1 then XOFF2 pauses, with code 3. The two bytes must be consecutive received bytes. Any other byte between them cancels the pair, and a lone character has no effect.
- R6: When `cfg_pin_addr` is 1, the XOFF2 comparison value is {`cfg_xoff2`[7:4], `addr_pins`}, and the stored low nibble is ignored. When `cfg_pin_addr` is 0, the comparison value is `cfg_xoff2` unchanged.
- R7: When `fifo_level` reaches `cfg_hi_mark` or more, one stop request is issued. No further stop request follows until `fifo_level` has fallen to `cfg_lo_mark` or less, and that fall issues exactly one resume request.
- R8: Mode bits [1:0] select the inserted characters:
  - 10 inserts XOFF1 or XON1.
  - 01 inserts XOFF2 or XON2, using the stored XOFF2 value.
  - 11 inserts XOFF1 then XOFF2, or XON1 then XON2.
- R9: `tx_ins_valid` stays high and `tx_ins_data` stays stable until `tx_ins_ready` is sampled high at a clock edge.
- R10: Inserted characters are requested and accepted even while `tx_paused` is 1, and insertion does not change `tx_paused`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 4 | [3:2] receive matching, [1:0] transmit insertion |
| cfg_pin_addr | input | 1 | Take the XOFF2 match low nibble from the address pins |
| cfg_xon1 | input | CHAR_W | First-set resume character |
| cfg_xon2 | input | CHAR_W | Second-set resume character |
| cfg_xoff1 | input | CHAR_W | First-set stop character |
| cfg_xoff2 | input | CHAR_W | Second-set stop character |
| addr_pins | input | PIN_W | External address pin levels |
| rx_data | input | CHAR_W | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| cfg_hi_mark | input | LVL_W | Upper fill mark |
| cfg_lo_mark | input | LVL_W | Lower fill mark |
| tx_ins_ready | input | 1 | Transmitter accepts the inserted character |
| tx_ins_valid | output | 1 | Insert request |
| tx_ins_data | output | CHAR_W | Character to insert |
| tx_paused | output | 1 | Transmitter pause state |
| spec_det | output | 1 | One-cycle special-character detection pulse |
| spec_code | output | 2 | Code of the last detected character |

## Verification
The assertions assume several things about the inputs:
- The mode field and the character registers do not change while an insert request is waiting for `tx_ins_ready`.
- `cfg_lo_mark` is below `cfg_hi_mark`.
- `rx_valid` is low while reset is applied.

The stimulus respects these assumptions in a specific way. Configuration changes only while reset is held, or while the insertion machine is idle in a wait state. The marks stay fixed at 96 and 32. The four characters are kept distinct, so that no byte matches two roles at once.

// File: rtl/xflow_pkg.sv
package xflow_pkg;

    typedef enum logic [1:0] {
        CH_XON1  = 2'd0,
        CH_XON2  = 2'd1,
        CH_XOFF1 = 2'd2,
        CH_XOFF2 = 2'd3
    } ch_code_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HAVE_ON,
        RX_HAVE_OFF
    } rx_state_e;

    typedef enum logic [2:0] {
        TQ_ON_WAIT,
        TQ_OFF_A,
        TQ_OFF_B,
        TQ_OFF_WAIT,
        TQ_ON_A,
        TQ_ON_B
    } tq_state_e;

    localparam logic [1:0] SEL_NONE   = 2'b00;
    localparam logic [1:0] SEL_SECOND = 2'b01;
    localparam logic [1:0] SEL_FIRST  = 2'b10;
    localparam logic [1:0] SEL_BOTH   = 2'b11;

endpackage

// File: rtl/xflow_pin_key.sv
module xflow_pin_key #(
    parameter int CHAR_W = 8,
    parameter int PIN_W  = 4
) (
    input  logic              use_pins,
    input  logic [CHAR_W-1:0] stored,
    input  logic [PIN_W-1:0]  pins,
    output logic [CHAR_W-1:0] key
);
    generate
        if (PIN_W >= CHAR_W) begin : g_all_pins
            assign key = use_pins ? pins[CHAR_W-1:0] : stored;
        end else begin : g_low_pins
            assign key = use_pins ? {stored[CHAR_W-1:PIN_W], pins} : stored;
        end
    endgenerate
endmodule

// File: rtl/xflow_rx_match.sv
module xflow_rx_match
    import xflow_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rx_sel,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2_key,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              paused,
    output logic              det,
    output logic [1:0]        det_code
);
    rx_state_e st_q, st_d;
    ch_code_e  code_d;
    logic      ev_on, ev_off;
    logic      hit_on1, hit_on2, hit_off1, hit_off2;

    assign hit_on1  = (rx_data == xon1);
    assign hit_on2  = (rx_data == xon2);
    assign hit_off1 = (rx_data == xoff1);
    assign hit_off2 = (rx_data == xoff2_key);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // next state and match events
    always_comb begin
        st_d   = st_q;
        ev_on  = 1'b0;
        ev_off = 1'b0;
        code_d = CH_XON1;
        if (rx_sel != SEL_BOTH) begin
            st_d = RX_IDLE;
        end
        if (rx_valid) begin
            unique case (rx_sel)
                SEL_FIRST: begin
                    if (hit_off1)     begin ev_off = 1'b1; code_d = CH_XOFF1; end
                    else if (hit_on1) begin ev_on  = 1'b1; code_d = CH_XON1;  end
                end
                SEL_SECOND: begin
                    if (hit_off2)     begin ev_off = 1'b1; code_d = CH_XOFF2; end
                    else if (hit_on2) begin ev_on  = 1'b1; code_d = CH_XON2;  end
                end
                SEL_BOTH: begin
                    if (st_q == RX_HAVE_ON && hit_on2) begin
                        ev_on  = 1'b1;
                        code_d = CH_XON2;
                        st_d   = RX_IDLE;
                    end else if (st_q == RX_HAVE_OFF && hit_off2) begin
                        ev_off = 1'b1;
                        code_d = CH_XOFF2;
                        st_d   = RX_IDLE;
                    end else if (hit_off1) begin
                        st_d = RX_HAVE_OFF;
                    end else if (hit_on1) begin
                        st_d = RX_HAVE_ON;
                    end else begin
                        st_d = RX_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused   <= 1'b0;
            det      <= 1'b0;
            det_code <= 2'd0;
        end else begin
            det <= ev_on | ev_off;
            if (ev_off)     paused <= 1'b1;
            else if (ev_on) paused <= 1'b0;
            if (ev_on | ev_off) det_code <= code_d;
        end
    end
endmodule

// File: rtl/xflow_tx_req.sv
module xflow_tx_req
    import xflow_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tx_sel,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  hi_mark,
    input  logic [LVL_W-1:0]  lo_mark,
    input  logic              ins_ready,
    output logic              ins_valid,
    output logic [CHAR_W-1:0] ins_data
);
    tq_state_e st_q, st_d;
    logic      pair;

    assign pair = (tx_sel == SEL_BOTH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TQ_ON_WAIT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (tx_sel == SEL_NONE) begin
            st_d = TQ_ON_WAIT;
        end else begin
            unique case (st_q)
                TQ_ON_WAIT:  if (level >= hi_mark) st_d = TQ_OFF_A;
                TQ_OFF_A:    if (ins_ready) st_d = pair ? TQ_OFF_B : TQ_OFF_WAIT;
                TQ_OFF_B:    if (ins_ready) st_d = TQ_OFF_WAIT;
                TQ_OFF_WAIT: if (level <= lo_mark) st_d = TQ_ON_A;
                TQ_ON_A:     if (ins_ready) st_d = pair ? TQ_ON_B : TQ_ON_WAIT;
                TQ_ON_B:     if (ins_ready) st_d = TQ_ON_WAIT;
                default:     st_d = TQ_ON_WAIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        ins_valid = 1'b0;
        ins_data  = xon1;
        unique case (st_q)
            TQ_OFF_A: begin ins_valid = 1'b1; ins_data = (tx_sel == SEL_SECOND) ? xoff2 : xoff1; end
            TQ_OFF_B: begin ins_valid = 1'b1; ins_data = xoff2; end
            TQ_ON_A:  begin ins_valid = 1'b1; ins_data = (tx_sel == SEL_SECOND) ? xon2 : xon1; end
            TQ_ON_B:  begin ins_valid = 1'b1; ins_data = xon2; end
            default: ;
        endcase
    end
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl #(
    parameter int CHAR_W = 8,
    parameter int PIN_W  = 4,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_mode,
    input  logic              cfg_pin_addr,
    input  logic [CHAR_W-1:0] cfg_xon1,
    input  logic [CHAR_W-1:0] cfg_xon2,
    input  logic [CHAR_W-1:0] cfg_xoff1,
    input  logic [CHAR_W-1:0] cfg_xoff2,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  cfg_hi_mark,
    input  logic [LVL_W-1:0]  cfg_lo_mark,
    input  logic              tx_ins_ready,
    output logic              tx_ins_valid,
    output logic [CHAR_W-1:0] tx_ins_data,
    output logic              tx_paused,
    output logic              spec_det,
    output logic [1:0]        spec_code
);
    logic [CHAR_W-1:0] xoff2_key;

    xflow_pin_key #(.CHAR_W(CHAR_W), .PIN_W(PIN_W)) u_key (
        .use_pins (cfg_pin_addr),
        .stored   (cfg_xoff2),
        .pins     (addr_pins),
        .key      (xoff2_key)
    );

    xflow_rx_match #(.CHAR_W(CHAR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_sel    (cfg_mode[3:2]),
        .xon1      (cfg_xon1),
        .xon2      (cfg_xon2),
        .xoff1     (cfg_xoff1),
        .xoff2_key (xoff2_key),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .paused    (tx_paused),
        .det       (spec_det),
        .det_code  (spec_code)
    );

    xflow_tx_req #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_sel    (cfg_mode[1:0]),
        .xon1      (cfg_xon1),
        .xon2      (cfg_xon2),
        .xoff1     (cfg_xoff1),
        .xoff2     (cfg_xoff2),
        .level     (fifo_level),
        .hi_mark   (cfg_hi_mark),
        .lo_mark   (cfg_lo_mark),
        .ins_ready (tx_ins_ready),
        .ins_valid (tx_ins_valid),
        .ins_data  (tx_ins_data)
    );
endmodule

// File: rtl/xflow_ctrl_chk.sv
module xflow_ctrl_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cfg_mode,
    input logic              rx_valid,
    input logic              tx_ins_ready,
    input logic              tx_ins_valid,
    input logic [CHAR_W-1:0] tx_ins_data,
    input logic              tx_paused,
    input logic              spec_det,
    input logic [1:0]        spec_code
);
    AST_PAUSE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_paused) |-> $past(rx_valid) && ($past(cfg_mode[3:2]) != 2'b00)); // R3

    AST_DET_NEEDS_RX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        spec_det |-> $past(rx_valid) && ($past(cfg_mode[3:2]) != 2'b00)); // R2

    AST_PAUSE_ON_STOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_paused) |-> spec_det && spec_code[1]); // R3

    AST_RESUME_ON_GO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_paused) |-> spec_det && !spec_code[1]); // R3

    AST_INS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ins_valid && !tx_ins_ready |=> tx_ins_valid && $stable(tx_ins_data)); // R9

    AST_NO_INS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode[1:0]) == 2'b00) |-> !tx_ins_valid); // R2
endmodule

bind xflow_ctrl xflow_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .rx_valid     (rx_valid),
    .tx_ins_ready (tx_ins_ready),
    .tx_ins_valid (tx_ins_valid),
    .tx_ins_data  (tx_ins_data),
    .tx_paused    (tx_paused),
    .spec_det     (spec_det),
    .spec_code    (spec_code)
);

// File: tb/xflow_ctrl_bench.sv
module xflow_ctrl_bench;
    localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h21, XOFF1 = 8'h13, XOFF2 = 8'h23;
    localparam logic [7:0] HI = 8'd96, LO = 8'd32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_mode = 4'h0;
    logic       cfg_pin_addr = 1'b0;
    logic [3:0] addr_pins = 4'h0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] fifo_level = 8'd0;
    logic       tx_ins_ready = 1'b1;
    logic       tx_ins_valid;
    logic [7:0] tx_ins_data;
    logic       tx_paused;
    logic       spec_det;
    logic [1:0] spec_code;

    always #5 clk = ~clk;

    xflow_ctrl #(.CHAR_W(8), .PIN_W(4), .LVL_W(8)) u_xflow_ctrl (
        .clk (clk), .rst_n (rst_n), .cfg_mode (cfg_mode), .cfg_pin_addr (cfg_pin_addr),
        .cfg_xon1 (XON1), .cfg_xon2 (XON2), .cfg_xoff1 (XOFF1), .cfg_xoff2 (XOFF2),
        .addr_pins (addr_pins), .rx_data (rx_data), .rx_valid (rx_valid),
        .fifo_level (fifo_level), .cfg_hi_mark (HI), .cfg_lo_mark (LO),
        .tx_ins_ready (tx_ins_ready), .tx_ins_valid (tx_ins_valid), .tx_ins_data (tx_ins_data),
        .tx_paused (tx_paused), .spec_det (spec_det), .spec_code (spec_code)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // log of accepted inserted characters
    logic [7:0] ins_log [0:63];
    int ins_n = 0;
    always @(posedge clk) begin
        if (rst_n && tx_ins_valid && tx_ins_ready) begin
            if (ins_n < 64) ins_log[ins_n] = tx_ins_data;
            ins_n = ins_n + 1;
        end
    end

    // behavioural model of the receive side
    logic       m_paused;
    logic       m_det;
    logic [1:0] m_code;
    int         m_pend;  // 0 none, 1 have XON1, 2 have XOFF1

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_valid = 1'b0;
        fifo_level = 8'd0;
        tx_ins_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_paused = 1'b0;
        m_pend = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_data = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic model_byte(input logic [1:0] sel, input logic [7:0] b, input logic [7:0] off2);
        m_det = 1'b0;
        case (sel)
            2'b10: begin
                if (b == XOFF1)     begin m_paused = 1'b1; m_det = 1'b1; m_code = 2'd2; end
                else if (b == XON1) begin m_paused = 1'b0; m_det = 1'b1; m_code = 2'd0; end
            end
            2'b01: begin
                if (b == off2)      begin m_paused = 1'b1; m_det = 1'b1; m_code = 2'd3; end
                else if (b == XON2) begin m_paused = 1'b0; m_det = 1'b1; m_code = 2'd1; end
            end
            2'b11: begin
                if (m_pend == 1 && b == XON2) begin
                    m_paused = 1'b0; m_det = 1'b1; m_code = 2'd1; m_pend = 0;
                end else if (m_pend == 2 && b == off2) begin
                    m_paused = 1'b1; m_det = 1'b1; m_code = 2'd3; m_pend = 0;
                end else if (b == XOFF1) m_pend = 2;
                else if (b == XON1)      m_pend = 1;
                else                     m_pend = 0;
            end
            default: ;
        endcase
    endtask

    task automatic t_reset();
        cfg_mode = 4'hF;
        do_reset();
        chk("R1 paused", tx_paused, 0);
        chk("R1 det", spec_det, 0);
        chk("R1 ins_valid", tx_ins_valid, 0);
    endtask

    // all 16 modes: receive stream against the model, then threshold insertion
    task automatic t_sweep();
        logic [7:0] stream [0:13];
        stream = '{XOFF1, XON1, XOFF2, XON2, XOFF1, 8'h55, XOFF2, XON1, XON2, XOFF1, XOFF2, XON1, 8'h55, XON2};
        cfg_pin_addr = 1'b0;
        for (int m = 0; m < 16; m++) begin
            string rtag;
            string ttag;
            int base;
            int nexp;
            logic [7:0] e0, e1;
            cfg_mode = m[3:0];
            do_reset();
            case (m[3:2])
                2'b00:   rtag = "R2";
                2'b10:   rtag = "R3";
                2'b01:   rtag = "R4";
                default: rtag = "R5";
            endcase
            for (int i = 0; i < 14; i++) begin
                send_byte(stream[i]);
                model_byte(m[3:2], stream[i], XOFF2);
                chk({rtag, " paused"}, tx_paused, m_paused);
                chk({rtag, " det"}, spec_det, m_det);
                if (m_det) chk({rtag, " code"}, spec_code, m_code);
            end
            ttag = (m[1:0] == 2'b00) ? "R2" : "R8";
            nexp = (m[1:0] == 2'b00) ? 0 : ((m[1:0] == 2'b11) ? 2 : 1);
            // stop request on rising to the upper mark
            base = ins_n;
            fifo_level = HI;
            repeat (8) @(negedge clk);
            chk({ttag, " stop count"}, ins_n - base, nexp);
            e0 = (m[1:0] == 2'b01) ? XOFF2 : XOFF1;
            if (nexp >= 1) chk({ttag, " stop char0"}, ins_log[base], e0);
            if (nexp == 2) chk({ttag, " stop char1"}, ins_log[base+1], XOFF2);
            // stays high: no repeat
            base = ins_n;
            fifo_level = HI + 8'd10;
            repeat (6) @(negedge clk);
            fifo_level = 8'd50;
            repeat (4) @(negedge clk);
            chk("R7 once per crossing", ins_n - base, 0);
            // resume request on falling to the lower mark
            base = ins_n;
            fifo_level = LO;
            repeat (8) @(negedge clk);
            chk({ttag, " go count"}, ins_n - base, nexp);
            e1 = (m[1:0] == 2'b01) ? XON2 : XON1;
            if (nexp >= 1) chk({ttag, " go char0"}, ins_log[base], e1);
            if (nexp == 2) chk({ttag, " go char1"}, ins_log[base+1], XON2);
            base = ins_n;
            fifo_level = 8'd5;
            repeat (4) @(negedge clk);
            chk("R7 no repeat below mark", ins_n - base, 0);
        end
    endtask

    task automatic t_pin_addr();
        cfg_mode = 4'b0100;
        cfg_pin_addr = 1'b1;
        addr_pins = 4'h7;
        do_reset();
        send_byte(XOFF2);  // stored low nibble ignored
        chk("R6 stored nibble ignored paused", tx_paused, 0);
        chk("R6 stored nibble ignored det", spec_det, 0);
        send_byte({XOFF2[7:4], 4'h7});
        chk("R6 pin key pauses", tx_paused, 1);
        chk("R6 pin key code", spec_code, 3);
        send_byte(XON2);
        chk("R4 resume", tx_paused, 0);
        cfg_pin_addr = 1'b0;
        send_byte(XOFF2);
        chk("R6 option off uses stored", tx_paused, 1);
        addr_pins = 4'h0;
    endtask

    task automatic t_handshake();
        cfg_mode = 4'b0011;
        cfg_pin_addr = 1'b0;
        do_reset();
        tx_ins_ready = 1'b0;
        fifo_level = HI;
        @(negedge clk);
        chk("R9 valid raised", tx_ins_valid, 1);
        chk("R9 first char", tx_ins_data, XOFF1);
        repeat (3) @(negedge clk);
        chk("R9 valid held", tx_ins_valid, 1);
        chk("R9 data held", tx_ins_data, XOFF1);
        tx_ins_ready = 1'b1;
        @(negedge clk);
        chk("R8 second char of pair", tx_ins_data, XOFF2);
        @(negedge clk);
        chk("R9 done after accept", tx_ins_valid, 0);
    endtask

    task automatic t_paused_insert();
        int base;
        cfg_mode = 4'b1010;
        do_reset();
        send_byte(XOFF1);
        chk("R3 paused", tx_paused, 1);
        base = ins_n;
        fifo_level = HI;
        repeat (6) @(negedge clk);
        chk("R10 inserted while paused", ins_n - base, 1);
        chk("R10 char", ins_log[base], XOFF1);
        chk("R10 pause unchanged", tx_paused, 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_pin_addr();
        t_handshake();
        t_paused_insert();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule